// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked control core of a pipelined synchronous burst SRAM, with the storage array modelled in behavioural form inside it. On every rising clock edge it looks at three chip selects, two address strobes, an advance input, the write enables and a sleep input. From these it decides the kind of cycle: sleep, deselect, burst start, burst step or burst hold. It then reads or writes one word of the internal array at the address that results.

There are two strobes. The processor-side strobe always starts a read, whatever the write enables show. The controller-side strobe starts either a read or a write. Once a burst is under way, both strobes stay high and the advance input chooses between stepping to the next burst address and holding the current one. The burst counter covers only the low address bits, and the bits above it keep the value loaded when the burst started.

Read data passes through one register and is driven one clock after the cycle that asked for it. The drive enable is gated without a clock by an active-low output enable. The data bus is a plain SRAM bus with no flow control. Each clock edge is one transfer and there is no back-pressure: a host that cannot take a read word must hold the burst with the advance input, or let the output enable float the bus.

Top module: `sbs_ctrl`

## Requirements
- R1: While `doze` is high, every other input is ignored. No array word is written, the burst address does not change, and `rd_drive` is low after that edge.
- R2: A cycle is a deselect, and `rd_drive` is low after its edge, in two cases. (a) `ctl_strb_n` is low while `sel_a_n` is high. (b) Either strobe is low (the processor strobe only while `sel_a_n` is low), and `sel_b` is low or `sel_c_n` is high.
- R3: When the chip is selected (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) and an effective strobe is low, a burst starts at `ext_addr`, and that word is read or written.
- R4: A start through `cpu_strb_n` (with `sel_a_n` low) is always a read, even when `all_wr_n` or `lane_wr_n` with the lane enables ask for a write.
- R5: Outside R4, a cycle writes when `all_wr_n`=0, or when `lane_wr_n`=0 and at least one bit of `lane_en_n` is 0. In every other case it reads.
- R6: With both strobes high (`cpu_strb_n` counts as high whenever `sel_a_n` is high) and `step_n`=0, the burst moves to the next address and reads or writes there.
- R7: With both strobes high and `step_n`=1, the burst stays on the current address and reads or writes there again.
- R8: The burst step adds one to the low 2 address bits and wraps from 3 to 0. The upper address bits keep the value loaded at burst start.
- R9: A write with `all_wr_n`=0 updates every byte lane. Otherwise it updates only the lanes whose `lane_en_n` bit is 0. Bit i of `lane_en_n` controls `wr_data` bits [8i+7:8i].
- R10: `rd_drive` is high only after a read cycle (start, step or hold) and only while `out_en_n` is low. It follows `out_en_n` without waiting for a clock edge and is low after a write cycle. `rd_data` carries the word read one edge earlier.
- R11: While `rst_n` is low, `rd_drive` is low, and the burst address resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low (high holds) |
| all_wr_n | input | 1 | Global write, active low, all lanes |
| lane_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| doze | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| ext_addr | input | ADDR_W | External address loaded on burst start |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | High when the data bus is driven |

## Verification
The bench starts a processor-strobe cycle with every write enable asserted. A design that let the write through would overwrite the word, and a later read of the same word after the burst wraps would show it. A four-beat controller write burst and a burst that starts at offset 3 check the counter. A wrong counter would either leave its range or disturb the upper address bits, and the later reads would come back from the wrong words. A hold in the middle of a burst, partial lane writes, a lane qualifier with no lanes enabled, and a sleep cycle that carries a write follow. A design that got one of these wrong would move the address, corrupt a lane or write while asleep. The remaining tests check that deselects and writes float the bus, that the output enable acts without a clock edge, and that an asserted reset drops the drive.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_DOZE  = 3'd1,
    CYC_START = 3'd2,
    CYC_STEP  = 3'd3,
    CYC_HOLD  = 3'd4
  } cyc_e;

  typedef struct packed {
    cyc_e kind;
    logic wr;
  } cyc_t;

  function automatic logic cyc_active(input cyc_e k);
    return (k == CYC_START) || (k == CYC_STEP) || (k == CYC_HOLD);
  endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             doze,
  output cyc_t             cyc,
  output logic [LANES-1:0] lane_mask
);

  logic selected;
  logic cpu_go;
  logic wr_req;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  // the processor strobe counts only while the first select is low
  assign cpu_go   = !cpu_strb_n && !sel_a_n;
  assign wr_req   = !all_wr_n || (!lane_wr_n && !(&lane_en_n));

  always_comb begin
    cyc.kind = CYC_IDLE;
    cyc.wr   = 1'b0;
    if (doze) begin
      cyc.kind = CYC_DOZE;
    end else if (cpu_go) begin
      if (selected) cyc.kind = CYC_START;
    end else if (!ctl_strb_n) begin
      if (selected) begin
        cyc.kind = CYC_START;
        cyc.wr   = wr_req;
      end
    end else begin
      cyc.kind = step_n ? CYC_HOLD : CYC_STEP;
      cyc.wr   = wr_req;
    end
  end

  assign lane_mask = all_wr_n ? ~lane_en_n : {LANES{1'b1}};

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              kind,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] lo_next;
  logic [HI_W-1:0]    hi_keep;

  assign lo_next = cur_addr[BURST_W-1:0] + BURST_W'(1);
  assign hi_keep = cur_addr[ADDR_W-1:BURST_W];

  always_comb begin
    unique case (kind)
      CYC_START: eff_addr = ext_addr;
      CYC_STEP:  eff_addr = {hi_keep, lo_next};
      default:   eff_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (cyc_active(kind)) begin
      cur_addr <= eff_addr;
    end
  end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && lane_mask[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en) lane_q <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    step_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    doze,
  input  logic                    out_en_n,
  input  logic [ADDR_W-1:0]       ext_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  cyc_t              cyc;
  logic [LANES-1:0]  lane_mask;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              do_wr;
  logic              do_rd;
  logic              rd_live;

  sbs_decode #(.LANES(LANES)) u_decode (
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n),
    .step_n    (step_n),
    .all_wr_n  (all_wr_n),
    .lane_wr_n (lane_wr_n),
    .lane_en_n (lane_en_n),
    .doze      (doze),
    .cyc       (cyc),
    .lane_mask (lane_mask)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (cyc.kind),
    .ext_addr(ext_addr),
    .eff_addr(eff_addr),
    .cur_addr(cur_addr)
  );

  assign do_wr = rst_n && cyc_active(cyc.kind) && cyc.wr;
  assign do_rd = cyc_active(cyc.kind) && !cyc.wr;

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .wr_en    (do_wr),
    .lane_mask(lane_mask),
    .rd_en    (do_rd),
    .addr     (eff_addr),
    .wdata    (wr_data),
    .rdata    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_live <= 1'b0;
    else        rd_live <= do_rd;
  end

  // output enable is applied without a clock
  assign rd_drive = rd_live && !out_en_n;

endmodule

// File: rtl/sbs_ctrl_chk.sv
module sbs_ctrl_chk #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LANES   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              cpu_strb_n,
  input logic              ctl_strb_n,
  input logic              step_n,
  input logic              all_wr_n,
  input logic              lane_wr_n,
  input logic [LANES-1:0]  lane_en_n,
  input logic              doze,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              rd_drive
);

  logic sel_all, cpu_eff, strobes_hi, wr_ask, desel;
  assign sel_all    = !sel_a_n && sel_b && !sel_c_n;
  assign cpu_eff    = !cpu_strb_n && !sel_a_n;
  assign strobes_hi = !cpu_eff && ctl_strb_n;
  assign wr_ask     = !all_wr_n || (!lane_wr_n && (lane_en_n != {LANES{1'b1}}));
  assign desel      = (!ctl_strb_n && sel_a_n) ||
                      ((cpu_eff || !ctl_strb_n) && (!sel_b || sel_c_n));

  AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> !rd_drive); // R1
  AST_SLEEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> $stable(cur_addr)); // R1
  AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && desel) |=> !rd_drive); // R2
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && sel_all && (cpu_eff || !ctl_strb_n)) |=> (cur_addr == $past(ext_addr))); // R3
  AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && sel_all && cpu_eff) |=> (rd_drive == !out_en_n)); // R4
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && strobes_hi && step_n) |=> $stable(cur_addr)); // R7
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && strobes_hi && !step_n) |=>
      ((cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)) &&
       (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])))); // R8
  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && wr_ask && !cpu_eff && (ctl_strb_n || sel_all)) |=> !rd_drive); // R10
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rd_drive); // R10

endmodule

bind sbs_ctrl sbs_ctrl_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .cpu_strb_n(cpu_strb_n),
  .ctl_strb_n(ctl_strb_n),
  .step_n    (step_n),
  .all_wr_n  (all_wr_n),
  .lane_wr_n (lane_wr_n),
  .lane_en_n (lane_en_n),
  .doze      (doze),
  .out_en_n  (out_en_n),
  .ext_addr  (ext_addr),
  .cur_addr  (cur_addr),
  .rd_drive  (rd_drive)
);

// File: tb/sbs_ctrl_bench.sv
module sbs_ctrl_bench;

  localparam int ADDR_W = 8;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;
  localparam int NV     = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a_n, sel_b, sel_c_n, cpu_strb_n, ctl_strb_n, step_n;
  logic all_wr_n, lane_wr_n, doze, out_en_n;
  logic [LANES-1:0]  lane_en_n;
  logic [ADDR_W-1:0] ext_addr;
  logic [DW-1:0]     wr_data;
  logic [DW-1:0]     rd_data;
  logic              rd_drive;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sbs_ctrl u_sbs_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n), .doze(doze),
    .out_en_n(out_en_n), .ext_addr(ext_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // controls: sel_a_n sel_b sel_c_n | cpu ctl step | all_wr lane_wr | lane_en[1:0] | doze | oe_n
  localparam logic [52:0] VEC [NV] = '{
    {12'b010_101_01_11_0_1, 8'h10, 16'hA000, 1'b0, 16'h0000},
    {12'b010_110_01_11_0_1, 8'h00, 16'hA001, 1'b0, 16'h0000},
    {12'b010_110_01_11_0_1, 8'h00, 16'hA002, 1'b0, 16'h0000},
    {12'b010_110_01_11_0_1, 8'h00, 16'hA003, 1'b0, 16'h0000},
    {12'b010_101_01_11_0_1, 8'h23, 16'hB000, 1'b0, 16'h0000},
    {12'b010_110_01_11_0_1, 8'h00, 16'hB001, 1'b0, 16'h0000},
    {12'b010_011_00_00_0_0, 8'h10, 16'hFFFF, 1'b1, 16'hA000},
    {12'b010_110_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'hA001},
    {12'b010_111_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'hA001},
    {12'b010_110_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'hA002},
    {12'b010_110_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'hA003},
    {12'b010_110_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'hA000},
    {12'b010_101_11_11_0_0, 8'h20, 16'h0000, 1'b1, 16'hB001},
    {12'b010_101_11_11_0_0, 8'h23, 16'h0000, 1'b1, 16'hB000},
    {12'b010_101_10_00_0_1, 8'h30, 16'h1234, 1'b0, 16'h0000},
    {12'b010_101_10_10_0_1, 8'h30, 16'hABCD, 1'b0, 16'h0000},
    {12'b010_101_11_00_0_0, 8'h30, 16'h5555, 1'b1, 16'h12CD},
    {12'b010_101_10_11_0_0, 8'h30, 16'h5555, 1'b1, 16'h12CD},
    {12'b110_101_11_11_0_0, 8'h40, 16'h0000, 1'b0, 16'h0000},
    {12'b000_011_11_11_0_0, 8'h40, 16'h0000, 1'b0, 16'h0000},
    {12'b011_101_11_11_0_0, 8'h40, 16'h0000, 1'b0, 16'h0000},
    {12'b110_011_11_11_0_0, 8'h40, 16'h0000, 1'b1, 16'h12CD},
    {12'b010_101_01_11_1_0, 8'h30, 16'h0000, 1'b0, 16'h0000},
    {12'b010_111_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'h12CD},
    {12'b010_111_11_11_0_1, 8'h00, 16'h0000, 1'b0, 16'h0000},
    {12'b010_111_01_11_0_0, 8'h00, 16'h7777, 1'b0, 16'h0000},
    {12'b010_111_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'h7777},
    {12'b110_010_01_11_0_0, 8'h00, 16'h8888, 1'b0, 16'h0000},
    {12'b010_111_11_11_0_0, 8'h00, 16'h0000, 1'b1, 16'h8888}
  };

  function automatic string tag_of(input int i);
    if (i <= 3)  return "R3";
    if (i <= 5)  return "R8";
    if (i == 6)  return "R4";
    if (i == 7)  return "R6";
    if (i == 8)  return "R7";
    if (i <= 11) return "R8";
    if (i <= 13) return "R3";
    if (i <= 15) return "R9";
    if (i <= 17) return "R5";
    if (i <= 20) return "R2";
    if (i == 21) return "R6";
    if (i <= 23) return "R1";
    if (i <= 26) return "R10";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic got_en, input logic exp_en,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got_en !== exp_en || (exp_en && got !== exp)) begin
      n_fail++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, got_en, got, exp_en, exp);
    end
  endtask

  task automatic idle_inputs();
    {sel_a_n, sel_b, sel_c_n} = 3'b010;
    {cpu_strb_n, ctl_strb_n, step_n} = 3'b111;
    {all_wr_n, lane_wr_n} = 2'b11;
    lane_en_n = '1;
    doze = 1'b0;
    out_en_n = 1'b1;
    ext_addr = '0;
    wr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R11", rd_drive, 1'b0, rd_data, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sel_a_n, sel_b, sel_c_n, cpu_strb_n, ctl_strb_n, step_n,
       all_wr_n, lane_wr_n, lane_en_n, doze, out_en_n} = VEC[i][52:41];
      ext_addr = VEC[i][40:33];
      wr_data  = VEC[i][32:17];
      @(posedge clk);
      #1;
      check(tag_of(i), rd_drive, VEC[i][16], rd_data, VEC[i][15:0]);
    end

    // output enable acts without a clock edge (R10)
    @(negedge clk);
    #1;
    out_en_n = 1'b1;
    #1;
    check("R10", rd_drive, 1'b0, rd_data, '0);
    out_en_n = 1'b0;
    #1;
    check("R10", rd_drive, 1'b1, rd_data, 16'h8888);

    // reset asserted mid-run drops the drive at once (R11)
    rst_n = 1'b0;
    #1;
    check("R11", rd_drive, 1'b0, rd_data, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // after reset the address is zero: a hold read at word 0 after writing it
    @(negedge clk);
    {cpu_strb_n, ctl_strb_n, step_n} = 3'b111;
    {all_wr_n, lane_wr_n} = 2'b01;
    wr_data = 16'h0F0F;
    @(posedge clk);
    @(negedge clk);
    {all_wr_n, lane_wr_n} = 2'b11;
    @(posedge clk);
    #1;
    check("R11", rd_drive, 1'b1, rd_data, 16'h0F0F);
    @(negedge clk);
    ext_addr = 8'h10;
    ctl_strb_n = 1'b0;
    @(posedge clk);
    #1;
    check("R3", rd_drive, 1'b1, rd_data, 16'hA000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule